// File: doc/BRIEF.md
# Flash Page Check-Word Repair Engine

This block takes the stored check words read back from a flash page's spare area and the check words freshly computed over the page data, and decides for each 512-byte sector whether that sector is intact. A pulse on `start` latches one stored and one computed 32-bit word per sector. The block then walks the sectors in ascending order, one sector per cycle. For each sector it reports one of four outcomes: clean, repaired, skipped (an erased sector, or damage that lies only in the check word), or unrepairable. It raises `done` for one cycle when the walk ends.

The difference between the two words of a sector is masked into two 12-bit halves. The odd half is bits 27:16 and the even half is bits 11:0. When the two halves are exact complements, the odd half names the flipped data bit. Its upper nine bits give the byte within the sector and its low three bits give the bit within that byte. The block then repairs the page buffer itself through a byte-wide RAM port with one-cycle read latency, using one read cycle followed by one write cycle. An unrepairable sector ends the walk at once.

Top module: `nand_ecc_fixer`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `ram_re` and `ram_we` are low, and `sector_status` and `result` are zero.
- R2: When every stored word equals its computed word, `result` is 0 (clean), every sector status is 00, and the RAM port stays idle.
- R3: A sector whose stored word equals its computed word gets status 00 and is never written, even when other sectors differ.
- R4: A sector whose stored word is 0xFFFFFFFF and differs from its computed word gets status 10 (skipped), and no repair is attempted.
- R5: The syndrome is (stored XOR computed) AND 0x0FFF0FFF. If it has zero or one bit set, the sector gets status 10 and the data is left unchanged. This includes a difference that lies only in bits 31:28 or 15:12.
- R6: If the syndrome has at least two bits set and odd half XOR even half is not 0xFFF, the sector gets status 11, `result` is 2, and the walk stops. Later sectors keep status 00 and are not repaired.
- R7: Otherwise the sector gets status 01. Bit odd[2:0] of page byte (sector × 512 + odd[11:3]) is inverted, and `fix_bit` shows odd[2:0] during the write.
- R8: When at least one sector differs and none is unrepairable, `result` is 1.
- R9: Sectors are visited in the order 0, 1, 2, 3, so repairs reach the RAM in ascending sector order. Several sectors of one page can each be repaired.
- R10: Each repair is one cycle of `ram_re` with the address, followed by exactly one cycle of `ram_we` at the same address. During the write, `ram_wdata` is the returned byte with one bit inverted. The port is idle at all other times.
- R11: `done` is high for exactly one cycle at the end of a walk. `sector_status` (sector k in bits 2k+1:2k) and `result` then hold until the next accepted `start`.
- R12: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch the check words and begin a walk (taken only when idle) |
| stored_ecc | input | 128 | Stored check words, sector k in bits 32k+31:32k |
| calc_ecc | input | 128 | Computed check words, same packing |
| ram_rdata | input | 8 | Byte returned by the page RAM one cycle after `ram_re` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| result | output | 2 | 0 clean, 1 handled mismatch, 2 unrepairable |
| sector_status | output | 8 | Two bits per sector: 00 clean, 01 repaired, 10 skipped, 11 unrepairable |
| ram_re | output | 1 | Page RAM read strobe |
| ram_we | output | 1 | Page RAM write strobe |
| ram_addr | output | 11 | Page byte address (sector, byte offset) |
| ram_wdata | output | 8 | Repaired byte |
| fix_bit | output | 3 | Bit index being inverted, valid with `ram_we` |

## Verification
The assertions check the port discipline on every cycle. Read and write never overlap, the address holds across the write, the port is silent while idle, `done` lasts one cycle, and status and result stay frozen between walks. The bench scenarios are needed to show the decoding itself. They show which sector lands in which of the four outcomes, the exact byte address and bit that get inverted, the ascending order of several repairs, and the early stop after an unrepairable sector. The bench confirms these against a page image whose expected contents it tracks independently.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_SKIP  = 2'b10,
    ST_BAD   = 2'b11
  } sec_stat_e;

  typedef enum logic [1:0] {
    RES_CLEAN   = 2'd0,
    RES_HANDLED = 2'd1,
    RES_FAIL    = 2'd2
  } page_res_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SCAN,
    S_RD,
    S_WR
  } walk_state_e;

endpackage

// File: rtl/ecc_fix_classify.sv
module ecc_fix_classify
  import ecc_fix_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 12,
  parameter int ODD_LSB = 16
) (
  input  logic [WORD_W-1:0] stored,
  input  logic [WORD_W-1:0] calc,
  output sec_stat_e         stat,
  output logic [HALF_W-1:0] loc
);

  localparam int SYN_W = 2 * HALF_W;

  logic [WORD_W-1:0] diff;
  logic [HALF_W-1:0] odd_h, even_h;
  logic [SYN_W-1:0]  syn;
  logic              sparse;

  assign diff   = stored ^ calc;
  assign odd_h  = diff[ODD_LSB +: HALF_W];
  assign even_h = diff[0 +: HALF_W];
  assign syn    = {odd_h, even_h};
  // zero or one bit set in the masked syndrome
  assign sparse = ((syn & (syn - SYN_W'(1))) == '0);
  assign loc    = odd_h;

  always_comb begin
    if (stored == calc)                 stat = ST_CLEAN;
    else if (stored == '1)              stat = ST_SKIP;
    else if (sparse)                    stat = ST_SKIP;
    else if ((odd_h ^ even_h) != '1)    stat = ST_BAD;
    else                                stat = ST_FIXED;
  end

endmodule

// File: rtl/ecc_fix_rmw.sv
module ecc_fix_rmw #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [BIT_W-1:0]  go_bit,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_re,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [BIT_W-1:0]  fix_bit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_re   <= 1'b0;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      fix_bit  <= '0;
    end else begin
      ram_re <= go;
      ram_we <= ram_re;
      if (go) begin
        ram_addr <= go_addr;
        fix_bit  <= go_bit;
      end
    end
  end

  assign ram_wdata = ram_rdata ^ (DATA_W'(1) << fix_bit);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(ram_re && ram_we)); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $stable(ram_addr) && $stable(fix_bit)); // R10

endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import ecc_fix_pkg::*;
#(
  parameter int SECTORS = 4,
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 12,
  parameter int ODD_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [SECTORS*WORD_W-1:0]   stored_ecc,
  input  logic [SECTORS*WORD_W-1:0]   calc_ecc,
  input  logic [7:0]                  ram_rdata,
  output logic                        busy,
  output logic                        done,
  output logic [1:0]                  result,
  output logic [2*SECTORS-1:0]        sector_status,
  output logic                        ram_re,
  output logic                        ram_we,
  output logic [$clog2(SECTORS)+HALF_W-3-1:0] ram_addr,
  output logic [7:0]                  ram_wdata,
  output logic [2:0]                  fix_bit
);

  localparam int BIT_W  = 3;
  localparam int OFS_W  = HALF_W - BIT_W;
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int ADDR_W = SEC_W + OFS_W;

  walk_state_e               st_q;
  logic [SEC_W-1:0]          sec_q;
  logic [SECTORS*WORD_W-1:0] stored_q, calc_q;
  logic [2*SECTORS-1:0]      status_q;
  page_res_e                 result_q;
  logic                      done_q, mism_q;

  sec_stat_e         stat_all [SECTORS];
  logic [HALF_W-1:0] loc_all  [SECTORS];

  for (genvar g = 0; g < SECTORS; g++) begin : g_cls
    ecc_fix_classify #(
      .WORD_W (WORD_W),
      .HALF_W (HALF_W),
      .ODD_LSB(ODD_LSB)
    ) u_cls (
      .stored(stored_q[g*WORD_W +: WORD_W]),
      .calc  (calc_q[g*WORD_W +: WORD_W]),
      .stat  (stat_all[g]),
      .loc   (loc_all[g])
    );
  end

  sec_stat_e         cur_stat;
  logic [HALF_W-1:0] cur_loc;
  logic              last, go;

  assign cur_stat = stat_all[sec_q];
  assign cur_loc  = loc_all[sec_q];
  assign last     = (sec_q == SEC_W'(SECTORS - 1));
  assign go       = (st_q == S_SCAN) && (cur_stat == ST_FIXED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      sec_q    <= '0;
      stored_q <= '0;
      calc_q   <= '0;
      status_q <= '0;
      result_q <= RES_CLEAN;
      done_q   <= 1'b0;
      mism_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            stored_q <= stored_ecc;
            calc_q   <= calc_ecc;
            status_q <= '0;
            result_q <= RES_CLEAN;
            sec_q    <= '0;
            mism_q   <= 1'b0;
            st_q     <= S_SCAN;
          end
        end
        S_SCAN: begin
          status_q[2*int'(sec_q) +: 2] <= cur_stat;
          if (cur_stat != ST_CLEAN) mism_q <= 1'b1;
          if (cur_stat == ST_BAD) begin
            result_q <= RES_FAIL;
            done_q   <= 1'b1;
            st_q     <= S_IDLE;
          end else if (cur_stat == ST_FIXED) begin
            st_q <= S_RD;
          end else if (last) begin
            result_q <= (mism_q || cur_stat != ST_CLEAN) ? RES_HANDLED : RES_CLEAN;
            done_q   <= 1'b1;
            st_q     <= S_IDLE;
          end else begin
            sec_q <= sec_q + SEC_W'(1);
          end
        end
        S_RD: st_q <= S_WR;
        S_WR: begin
          if (last) begin
            result_q <= RES_HANDLED;
            done_q   <= 1'b1;
            st_q     <= S_IDLE;
          end else begin
            sec_q <= sec_q + SEC_W'(1);
            st_q  <= S_SCAN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  ecc_fix_rmw #(
    .ADDR_W(ADDR_W),
    .DATA_W(8),
    .BIT_W (BIT_W)
  ) u_rmw (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_addr  ({sec_q, cur_loc[HALF_W-1:BIT_W]}),
    .go_bit   (cur_loc[BIT_W-1:0]),
    .ram_rdata(ram_rdata),
    .ram_re   (ram_re),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata),
    .fix_bit  (fix_bit)
  );

  assign busy          = (st_q != S_IDLE);
  assign done          = done_q;
  assign result        = result_q;
  assign sector_status = status_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ram_re && !ram_we); // R10
  AST_HOLD_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(sector_status) && $stable(result)); // R11
  AST_CLEAN_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd0) |-> sector_status == '0); // R2
  AST_FAIL_HAS_BAD: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd2) |-> sector_status != '0); // R6

endmodule

// File: tb/nand_ecc_fixer_bench.sv
`timescale 1ns/1ps
module nand_ecc_fixer_bench;

  typedef struct packed {
    logic [7:0]        st;
    logic [1:0]        res;
    logic [2:0]        nfix;
    logic [3:0][10:0]  addr;
    logic [3:0][2:0]   bitn;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] stored_ecc = '0;
  logic [127:0] calc_ecc = '0;
  logic [7:0]   ram_rdata;
  logic         busy, done, ram_re, ram_we;
  logic [1:0]   result;
  logic [7:0]   sector_status;
  logic [10:0]  ram_addr;
  logic [7:0]   ram_wdata;
  logic [2:0]   fix_bit;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] mem    [2048];
  logic [7:0] shadow [2048];
  exp_t q [$];
  exp_t cur_e;
  logic [31:0] sw [4];
  logic [31:0] cw [4];

  always #2 clk = ~clk;

  nand_ecc_fixer u_nand_ecc_fixer (
    .clk(clk), .rst(rst), .start(start),
    .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .result(result), .sector_status(sector_status),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .fix_bit(fix_bit)
  );

  // page buffer model, one-cycle read latency
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares as results appear
  int   fk = 0;
  bit   prev_re = 0;
  logic [10:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ram_we) begin
        if (q.size() == 0 || fk >= int'(q[0].nfix)) begin
          chk(0, "R3 unexpected write", 64'(ram_addr), 0);
        end else begin
          chk(ram_addr == q[0].addr[fk], "R9 repair address/order", 64'(ram_addr), 64'(q[0].addr[fk]));
          chk(ram_wdata == (mem[ram_addr] ^ (8'd1 << q[0].bitn[fk])) && fix_bit == q[0].bitn[fk],
              "R7 repaired byte", 64'(ram_wdata), 64'(mem[ram_addr] ^ (8'd1 << q[0].bitn[fk])));
          chk(prev_re && prev_addr == ram_addr, "R10 read precedes write", 64'(prev_addr), 64'(ram_addr));
        end
        fk++;
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R12 unexpected done", 1, 0);
        end else begin
          exp_t e;
          int bad;
          e = q.pop_front();
          chk(sector_status == e.st, "R3/R4/R5/R6/R7 sector status", 64'(sector_status), 64'(e.st));
          chk(result == e.res, "R8 result", 64'(result), 64'(e.res));
          chk(fk == int'(e.nfix), "R10 repair count", 64'(fk), 64'(e.nfix));
          bad = 0;
          for (int i = 0; i < 2048; i++) if (mem[i] !== shadow[i]) bad++;
          chk(bad == 0, "R7 page image", 64'(bad), 0);
        end
        fk = 0;
      end
      prev_re   = ram_re;
      prev_addr = ram_addr;
    end
  end

  function automatic logic [31:0] fix_word(input logic [31:0] c, input logic [11:0] o);
    return c ^ {4'h0, o, 4'h0, ~o};
  endfunction

  task automatic begin_case();
    cur_e = '0;
    for (int i = 0; i < 4; i++) begin
      cw[i] = 32'h0A5A_0C3C + 32'(i) * 32'h0101_0101;
      sw[i] = cw[i];
    end
  endtask

  task automatic add_fix(input int sec, input logic [11:0] o);
    logic [10:0] a;
    a = {2'(sec), o[11:3]};
    sw[sec] = fix_word(cw[sec], o);
    cur_e.addr[cur_e.nfix] = a;
    cur_e.bitn[cur_e.nfix] = o[2:0];
    cur_e.nfix = cur_e.nfix + 3'd1;
    shadow[a] = shadow[a] ^ (8'd1 << o[2:0]);
  endtask

  task automatic run_case(input logic [7:0] st, input logic [1:0] res, input bit glitch, input string req);
    cur_e.st  = st;
    cur_e.res = res;
    q.push_back(cur_e);
    @(negedge clk);
    start = 1'b1;
    stored_ecc = {sw[3], sw[2], sw[1], sw[0]};
    calc_ecc   = {cw[3], cw[2], cw[1], cw[0]};
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      @(negedge clk);
      start = 1'b1;                       // R12: arrives while busy
      stored_ecc = ~stored_ecc;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sector_status == st && result == res && !busy, {req, " R11 hold after done"},
        64'({busy, result, sector_status}), 64'({1'b0, res, st}));
  endtask

  function automatic logic [7:0] pk(input logic [1:0] s0, s1, s2, s3);
    return {s3, s2, s1, s0};
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ram_re && !ram_we && sector_status == 0 && result == 0,
        "R1 reset state", 64'({busy, done, ram_re, ram_we, result, sector_status}), 0);

    begin_case();                                               // R2
    run_case(8'h00, 2'd0, 0, "R2");

    begin_case(); add_fix(1, 12'h2A5);                          // R3 R7
    run_case(pk(2'b00, 2'b01, 2'b00, 2'b00), 2'd1, 0, "R3");

    begin_case();                                               // R9
    add_fix(0, 12'h123); add_fix(1, 12'h456); add_fix(2, 12'h789); add_fix(3, 12'hABC);
    run_case(pk(2'b01, 2'b01, 2'b01, 2'b01), 2'd1, 0, "R9");

    begin_case();                                               // R4 R5 R8
    sw[0] = 32'hFFFF_FFFF;
    sw[2] = cw[2] ^ 32'h0000_0020;
    sw[3] = cw[3] ^ 32'h4000_0000;
    run_case(pk(2'b10, 2'b00, 2'b10, 2'b10), 2'd1, 0, "R4 R5");

    begin_case(); add_fix(0, 12'h00A);                          // R6
    sw[1] = cw[1] ^ 32'h0003_0003;
    sw[2] = fix_word(cw[2], 12'h100);
    run_case(pk(2'b01, 2'b11, 2'b00, 2'b00), 2'd2, 0, "R6");

    begin_case();                                               // R6 first sector
    sw[0] = cw[0] ^ 32'h0F00_0F00;
    sw[3] = fix_word(cw[3], 12'h001);
    run_case(pk(2'b11, 2'b00, 2'b00, 2'b00), 2'd2, 0, "R6");

    begin_case(); add_fix(0, 12'h000); add_fix(3, 12'hFFF);     // R7 boundaries
    run_case(pk(2'b01, 2'b00, 2'b00, 2'b01), 2'd1, 0, "R7");

    begin_case(); add_fix(2, 12'h7C1);                          // R12
    sw[1] = cw[1] ^ 32'h0100_0000;
    run_case(pk(2'b00, 2'b10, 2'b01, 2'b00), 2'd1, 1, "R12");

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R11 all results seen", 64'(q.size()), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule